// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides which interrupt a 16550-style serial port reports and when it raises its interrupt line. It reads the interrupt enable bits, the receive status, a character-timeout flag, the receive FIFO fill level against its trigger level, and the modem-line change bits. From these it builds an 8-bit identification byte for software to read, using a fixed five-level priority scheme. It also drives a level-sensitive interrupt output.

The block holds the small amount of state that goes with interrupt identification. This covers the enable bits, a holding-register-empty status, and a sticky "transmitter empty pending" flag. Reading the identification byte clears that flag, and enabling the interrupt re-arms it. It also holds the sticky overrun and break bits, which a line-status read clears, and the sticky modem delta bits, which a modem-status read clears. Register decoding sits outside the block and supplies one-cycle access strobes. The shifters, the FIFO storage and baud generation are also outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification code in `iir[3:0]` follows a fixed priority, highest first:
  - 0x6 when enable bit 2 is set and any bit of `lsr_err` is set;
  - 0xC when enable bit 0 is set and `rx_timeout` is high;
  - 0x4 when the received-data condition of R3 holds;
  - 0x2 when enable bit 1 is set and the transmit-empty pending flag is set;
  - 0x0 when enable bit 3 is set and any bit of `modem_delta` is set.
- R2: With no active source, `iir[3:0]` is 0x1. `irq` is high exactly when `iir[3:0]` differs from 0x1.
- R3: The received-data condition needs enable bit 0 and `data_ready`. It also needs either `fifo_en` low, or `rx_count` greater than or equal to `rx_level`.
- R4: `iir[7:6]` is 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iir[5:4]` is always 0.
- R5: An `iir_rd` strobe in a cycle where `iir[3:0]` is 0x2 clears the pending flag from the next cycle. A read that shows another code leaves the flag set.
- R6: An `ier_wr` that takes enable bit 1 from 0 to 1 while `thr_empty` is high sets the pending flag. Writing 1 to a bit that is already 1 does not re-arm the flag. Any write with bit 1 at 0 clears the flag.
- R7: `thr_wr` clears `thr_empty` and the pending flag on the next cycle. `tx_drain` sets `thr_empty`, and also sets the pending flag when enable bit 1 is set.
- R8: The `lsr_err` field is laid out as follows:
  - bit 3 is break;
  - bit 2 is framing, which follows `frm_err`;
  - bit 1 is parity, which follows `par_err`;
  - bit 0 is overrun.
  Overrun and break are sticky: `ovr_set` and `brk_set` set them, and `lsr_rd` clears them. A set strobe in the same cycle as `lsr_rd` wins.
- R9: Each bit of `modem_delta` is the sticky OR of `msr_set`. `msr_rd` clears all four bits. A set bit in the same cycle as `msr_rd` wins.
- R10: After reset, `iir` is 0x01, `irq` is low, `thr_empty` is high, and `lsr_err` and `modem_delta` are zero. The enable bits and the pending flag are also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable bits written: 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| tx_drain | input | 1 | Transmitter has emptied the holding register or FIFO |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| ovr_set | input | 1 | Receive overrun event |
| brk_set | input | 1 | Break received event |
| par_err | input | 1 | Parity error of the current character (level) |
| frm_err | input | 1 | Framing error of the current character (level) |
| data_ready | input | 1 | Receive data present |
| rx_timeout | input | 1 | Character timeout pending |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_level | input | CNT_W | Receive trigger level |
| msr_set | input | 4 | Modem line change events |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |
| lsr_err | output | 4 | Line error bits {break, framing, parity, overrun} |
| modem_delta | output | 4 | Sticky modem change bits |
| thr_empty | output | 1 | Transmit holding register empty |

## Verification
A wrong pending flag shows up in `iir` the cycle after the strobe that should have moved it. The symptom is code 0x2 that stays after a read, or that fails to appear after an enable write. Either case is visible at the next sample. A priority fault shows at once as the wrong code for one combination of enables and sources, so the bench sweeps every combination of the four enable bits with the five sources. It also sweeps every pair of count and level. A sticky bit that is not cleared, or that is lost when a set strobe meets a read, stays visible in `lsr_err` or `modem_delta` until the next read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RDA  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rda;
    logic thr;
    logic mdm;
  } src_t;

  function automatic logic [3:0] pick_id(src_t s);
    logic [3:0] id;
    if (s.line)      id = ID_LINE;
    else if (s.tmo)  id = ID_TMO;
    else if (s.rda)  id = ID_RDA;
    else if (s.thr)  id = ID_THR;
    else if (s.mdm)  id = ID_MDM;
    else             id = ID_NONE;
    return id;
  endfunction

  function automatic logic rda_ready(logic en, logic dr, logic fe,
                                     logic [7:0] cnt, logic [7:0] lvl);
    return en && dr && (!fe || (cnt >= lvl));
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = clr ? '0 : q;
    q_n = q_n | set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ier_wr,
  input  logic ier_thr_new,
  input  logic ier_thr_cur,
  input  logic iir_rd,
  input  logic id_is_thr,
  input  logic thr_wr,
  input  logic tx_drain,
  output logic thre,
  output logic pend,
  output logic arm_evt,
  output logic off_evt,
  output logic ack_evt
);
  logic thre_n, pend_n, drain_evt;

  assign arm_evt   = ier_wr && ier_thr_new && !ier_thr_cur && thre;
  assign off_evt   = ier_wr && !ier_thr_new;
  assign ack_evt   = iir_rd && id_is_thr;
  assign drain_evt = tx_drain && ier_thr_cur;

  always_comb begin
    thre_n = thre;
    if (tx_drain) thre_n = 1'b1;
    if (thr_wr)   thre_n = 1'b0;
    pend_n = pend;
    if (drain_evt) pend_n = 1'b1;
    if (ack_evt)   pend_n = 1'b0;
    if (thr_wr)    pend_n = 1'b0;
    if (arm_evt)   pend_n = 1'b1;
    if (off_evt)   pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre <= 1'b1;
      pend <= 1'b0;
    end else begin
      thre <= thre_n;
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier,
  input  logic [3:0]       lsr_err,
  input  logic             rx_timeout,
  input  logic             data_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             thr_pend,
  input  logic [3:0]       modem_delta,
  output src_t             src,
  output logic [7:0]       iir,
  output logic             irq
);
  logic [3:0] id;
  logic [7:0] cnt8, lvl8;

  assign cnt8 = 8'(rx_count);
  assign lvl8 = 8'(rx_level);

  always_comb begin
    src.line = ier[2] && (|lsr_err);
    src.tmo  = ier[0] && rx_timeout;
    src.rda  = rda_ready(ier[0], data_ready, fifo_en, cnt8, lvl8);
    src.thr  = ier[1] && thr_pend;
    src.mdm  = ier[3] && (|modem_delta);
    id       = pick_id(src);
    iir      = {{2{fifo_en}}, 2'b00, id};
    irq      = (id != ID_NONE);
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             tx_drain,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             ovr_set,
  input  logic             brk_set,
  input  logic             par_err,
  input  logic             frm_err,
  input  logic             data_ready,
  input  logic             rx_timeout,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [3:0]       msr_set,
  output logic [7:0]       iir,
  output logic             irq,
  output logic [3:0]       lsr_err,
  output logic [3:0]       modem_delta,
  output logic             thr_empty
);
  logic [3:0] ier_q;
  logic [1:0] ob_q;
  logic       pend, arm_evt, off_evt, ack_evt;
  src_t       src;

  always_ff @(posedge clk) begin
    if (!rst_n)      ier_q <= 4'h0;
    else if (ier_wr) ier_q <= ier_wdata;
  end

  uart_irq_sticky #(.W(2)) u_ovr_brk (
    .clk(clk), .rst_n(rst_n), .set({brk_set, ovr_set}), .clr(lsr_rd), .q(ob_q)
  );

  uart_irq_sticky #(.W(4)) u_mdelta (
    .clk(clk), .rst_n(rst_n), .set(msr_set), .clr(msr_rd), .q(modem_delta)
  );

  assign lsr_err = {ob_q[1], frm_err, par_err, ob_q[0]};

  uart_irq_thre_track u_thre (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_thr_new(ier_wdata[1]),
    .ier_thr_cur(ier_q[1]), .iir_rd(iir_rd), .id_is_thr(iir[3:0] == ID_THR),
    .thr_wr(thr_wr), .tx_drain(tx_drain), .thre(thr_empty), .pend(pend),
    .arm_evt(arm_evt), .off_evt(off_evt), .ack_evt(ack_evt)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier(ier_q), .lsr_err(lsr_err), .rx_timeout(rx_timeout),
    .data_ready(data_ready), .fifo_en(fifo_en), .rx_count(rx_count),
    .rx_level(rx_level), .thr_pend(pend), .modem_delta(modem_delta),
    .src(src), .iir(iir), .irq(irq)
  );

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|lsr_err)) |-> (iir[3:0] == ID_LINE)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] == ID_NONE) |-> !irq); // R2
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    iir[7:4] == {fifo_en, fifo_en, 2'b00}); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == ID_THR && !ier_wr) |=> !pend); // R5
  AST_IER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !ier_wdata[1]) |=> (!pend && iir[3:0] != ID_THR)); // R6
  AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !ier_wr) |=> (!thr_empty && !pend)); // R7
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_set && !brk_set) |=> (!lsr_err[0] && !lsr_err[3])); // R8
  AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && msr_set == 4'h0) |=> (modem_delta == 4'h0)); // R9
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, iir_rd = 0, thr_wr = 0, tx_drain = 0, lsr_rd = 0, msr_rd = 0;
  logic ovr_set = 0, brk_set = 0, par_err = 0, frm_err = 0;
  logic data_ready = 0, rx_timeout = 0, fifo_en = 0;
  logic [3:0] ier_wdata = 0, msr_set = 0;
  logic [CW-1:0] rx_count = 0, rx_level = 0;
  logic [7:0] iir;
  logic irq, thr_empty;
  logic [3:0] lsr_err, modem_delta;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .iir_rd(iir_rd),
    .thr_wr(thr_wr), .tx_drain(tx_drain), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .ovr_set(ovr_set), .brk_set(brk_set), .par_err(par_err), .frm_err(frm_err),
    .data_ready(data_ready), .rx_timeout(rx_timeout), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_level(rx_level), .msr_set(msr_set), .iir(iir), .irq(irq),
    .lsr_err(lsr_err), .modem_delta(modem_delta), .thr_empty(thr_empty)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ier(logic [3:0] v);
    ier_wdata = v; ier_wr = 1; tick(); ier_wr = 0;
  endtask

  task automatic strobe_thr();   thr_wr = 1;   tick(); thr_wr = 0;   endtask
  task automatic strobe_drain(); tx_drain = 1; tick(); tx_drain = 0; endtask
  task automatic strobe_iir();   iir_rd = 1;   tick(); iir_rd = 0;   endtask
  task automatic strobe_msr();   msr_rd = 1;   tick(); msr_rd = 0;   endtask
  task automatic strobe_lsr();   lsr_rd = 1;   tick(); lsr_rd = 0;   endtask

  // expected code: walk a ranked list, first enabled active source wins
  function automatic logic [3:0] expect_id(logic [3:0] en, logic [4:0] act);
    logic [3:0] codes [5];
    logic [4:0] gated;
    codes[0] = 4'h6; codes[1] = 4'hC; codes[2] = 4'h4; codes[3] = 4'h2; codes[4] = 4'h0;
    gated = act & {en[2], en[0], en[0], en[1], en[3]};
    for (int k = 0; k < 5; k++)
      if (gated[4-k]) return codes[k];
    return 4'h1;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R10 reset state
    check("R10 iir", 16'(iir), 16'h01);
    check("R10 irq", 16'(irq), 16'h0);
    check("R10 thr_empty", 16'(thr_empty), 16'h1);
    check("R10 lsr_err", 16'(lsr_err), 16'h0);
    check("R10 modem_delta", 16'(modem_delta), 16'h0);
    tick();

    // R6 arm on rising enable with empty holding register; R5 ack
    wr_ier(4'h2); #1;
    check("R6 arm", 16'(iir), 16'h02);
    check("R2 irq on", 16'(irq), 16'h1);
    tick();
    strobe_iir(); #1;
    check("R5 ack clears", 16'(iir), 16'h01);
    check("R2 irq off", 16'(irq), 16'h0);
    tick();
    wr_ier(4'h2); #1;
    check("R6 no rearm when already set", 16'(iir), 16'h01);
    tick();
    wr_ier(4'h0); wr_ier(4'h2); #1;
    check("R6 rearm after toggle", 16'(iir), 16'h02);
    tick();
    wr_ier(4'h0); wr_ier(4'h2); wr_ier(4'h0); #1;
    check("R6 clear by disable", 16'(iir), 16'h01);
    wr_ier(4'h2); #1;
    check("R6 disable then enable arms", 16'(iir), 16'h02);

    // R7 thr write and drain
    strobe_thr(); #1;
    check("R7 thr_empty cleared", 16'(thr_empty), 16'h0);
    check("R7 pend cleared", 16'(iir), 16'h01);
    wr_ier(4'h0); wr_ier(4'h2); #1;
    check("R7 no arm while full", 16'(iir), 16'h01);
    strobe_drain(); #1;
    check("R7 drain sets empty", 16'(thr_empty), 16'h1);
    check("R7 drain raises pend", 16'(iir), 16'h02);

    // R5 read showing another code keeps pending
    wr_ier(4'h6); par_err = 1; #1;
    check("R1 line over thr", 16'(iir), 16'h06);
    tick(); strobe_iir(); par_err = 0; #1;
    check("R5 read of other code keeps flag", 16'(iir), 16'h02);
    wr_ier(4'h0);

    // R8 sticky overrun/break, level parity/framing
    ovr_set = 1; brk_set = 1; tick(); ovr_set = 0; brk_set = 0;
    par_err = 1; #1;
    check("R8 sticky set", 16'(lsr_err), 16'hB);
    strobe_lsr(); #1;
    check("R8 read clears OE BI", 16'(lsr_err), 16'h2);
    par_err = 0; frm_err = 1; #1;
    check("R8 framing level", 16'(lsr_err), 16'h4);
    frm_err = 0;
    ovr_set = 1; lsr_rd = 1; tick(); ovr_set = 0; lsr_rd = 0; #1;
    check("R8 set wins over read", 16'(lsr_err), 16'h1);
    strobe_lsr(); #1;
    check("R8 cleared", 16'(lsr_err), 16'h0);

    // R9 modem deltas
    msr_set = 4'h5; tick(); msr_set = 4'h8; tick(); msr_set = 0; #1;
    check("R9 sticky OR", 16'(modem_delta), 16'hD);
    msr_set = 4'h2; msr_rd = 1; tick(); msr_set = 0; msr_rd = 0; #1;
    check("R9 set wins over read", 16'(modem_delta), 16'h2);
    strobe_msr(); #1;
    check("R9 read clears", 16'(modem_delta), 16'h0);

    // R1 R2 R4 exhaustive: enables x sources, fifo off
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 32; m++) begin
        par_err = 0; rx_timeout = 0; data_ready = 0; fifo_en = 0;
        strobe_thr();
        wr_ier(4'(e));
        if (m[1]) strobe_drain();
        strobe_msr();
        if (m[0]) begin msr_set = 4'(1 << (e % 4)); tick(); msr_set = 0; end
        par_err = m[4]; rx_timeout = m[3]; data_ready = m[2];
        #1;
        check("R1 priority sweep", 16'(iir), {8'h0, 4'h0, expect_id(4'(e), 5'(m))});
        check("R2 irq sweep", 16'(irq), 16'(expect_id(4'(e), 5'(m)) != 4'h1));
        tick();
      end
    end
    par_err = 0; rx_timeout = 0; data_ready = 0;
    strobe_thr(); strobe_msr();

    // R3 R4 count vs level sweep, fifo on
    wr_ier(4'h1); fifo_en = 1;
    for (int c = 0; c <= 16; c++) begin
      for (int l = 0; l <= 16; l++) begin
        rx_count = CW'(c); rx_level = CW'(l); data_ready = 1; #1;
        check("R3 count>=level", 16'(iir), (c >= l) ? 16'hC4 : 16'hC1);
        data_ready = 0; #1;
        check("R3 needs data_ready", 16'(iir), 16'hC1);
        tick();
      end
    end
    rx_count = 0; rx_level = 5'd8; data_ready = 1; fifo_en = 0; #1;
    check("R4 fifo off ignores level", 16'(iir), 16'h04);
    data_ready = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule